// File: doc/BRIEF.md
# Logic, Single-Bit and Rotate Unit

This unit is one execution lane of an integer datapath with XLEN of 32 or 64 bits. It takes a first operand, a second operand and a separate immediate shift amount, plus an operation code, an immediate-select flag and a word-mode flag. It produces one XLEN-wide result, registered on the rising clock edge.

The operations fall into four groups: logic with an inverted second operand, signed and unsigned minimum and maximum, operations on a single bit at a chosen index, and rotations. The single-bit operations build a one-hot mask from the index. On a 64-bit datapath, word mode makes a rotation work on the low 32 bits only and sign-extend the 32-bit result. The immediate and register amounts share one datapath. Decode and pipeline control stay outside the unit.

Top module: `lsr_unit`

## Requirements
- R1: Op codes 0, 1 and 2 return `a & ~b`, `a | ~b` and `~(a ^ b)`, where `a` is `src_a` and `b` is `src_b`.
- R2: Op code 3 returns the smaller and op code 4 the larger of `a` and `b`, both read as two's-complement signed numbers.
- R3: Op code 5 returns the smaller and op code 6 the larger of `a` and `b`, both read as unsigned numbers.
- R4: Op codes 7, 8 and 9 set, clear and invert, respectively, the single bit of `a` at index k and leave every other bit as it is. The index k is the low log2(XLEN) bits of the selected amount.
- R5: Op code 10 returns bit k of `a` in bit 0, with every other result bit zero.
- R6: Op code 11 rotates `a` left by k places and op code 12 rotates it right by k places, over all XLEN bits. Here k is the low log2(XLEN) bits of the selected amount.
- R7: When XLEN is 64 and `word_mode` is 1, op codes 11 and 12 rotate only `a[31:0]` by the low 5 bits of the selected amount. They return the 32-bit result sign-extended to 64 bits, and bits 63:32 of both operands have no effect.
- R8: When `use_imm` is 1, the selected amount is `imm_amt` for op codes 7 to 10 and 12. Otherwise it is `src_b`. Op code 11 always uses `src_b` and ignores `imm_amt` and `use_imm`.
- R9: `word_mode` has no effect on op codes 0 to 10.
- R10: The result appears on `result` one clock after the inputs. While `rst_n` is low, `result` is zero.
- R11: Op codes 13 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand or register amount |
| imm_amt | input | log2(XLEN) | Immediate amount |
| use_imm | input | 1 | Take the amount from `imm_amt` |
| word_mode | input | 1 | 32-bit rotate with sign extension |
| result | output | XLEN | Registered result |

## Verification
The hardest cases to reach are the word rotations in which only the upper halves of the operands differ. This includes amounts whose bit 5 is set and must be dropped, while bit 31 of the rotated word decides the sign extension. The bench sweeps every amount from 0 to 63 in both directions. It uses operands whose upper half is random noise and whose low word holds a single marked bit, so a wrong truncation or a wrong extension changes the output. It also repeats the single-bit sweeps with `word_mode` raised and with the immediate field carrying a value that differs from the register amount. This checks which source each operation uses.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [3:0] {
        OP_ANDN = 4'd0,
        OP_ORN  = 4'd1,
        OP_XNOR = 4'd2,
        OP_MIN  = 4'd3,
        OP_MAX  = 4'd4,
        OP_MINU = 4'd5,
        OP_MAXU = 4'd6,
        OP_BSET = 4'd7,
        OP_BCLR = 4'd8,
        OP_BINV = 4'd9,
        OP_BEXT = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12
    } lsr_op_e;

    typedef enum logic [1:0] {
        GRP_LOGIC,
        GRP_BIT,
        GRP_ROT,
        GRP_NONE
    } lsr_grp_e;

    function automatic lsr_grp_e op_group(input logic [3:0] code);
        if (code <= 4'd6)       return GRP_LOGIC;
        else if (code <= 4'd10) return GRP_BIT;
        else if (code <= 4'd12) return GRP_ROT;
        else                    return GRP_NONE;
    endfunction

endpackage

// File: rtl/lsr_logic.sv
module lsr_logic
    import lsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic a_lt_b_s;
    logic a_lt_b_u;

    always_comb begin
        a_lt_b_s = $signed(a) < $signed(b);
        a_lt_b_u = a < b;
        case (op)
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_XNOR: y = ~(a ^ b);
            OP_MIN:  y = a_lt_b_s ? a : b;
            OP_MAX:  y = a_lt_b_s ? b : a;
            OP_MINU: y = a_lt_b_u ? a : b;
            OP_MAXU: y = a_lt_b_u ? b : a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/lsr_bitop.sv
module lsr_bitop
    import lsr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  idx,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] mask;

    always_comb begin
        mask = {{(XLEN-1){1'b0}}, 1'b1} << idx;
        case (op)
            OP_BSET: y = a | mask;
            OP_BCLR: y = a & ~mask;
            OP_BINV: y = a ^ mask;
            OP_BEXT: y = {{(XLEN-1){1'b0}}, |(a & mask)};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/lsr_rotate.sv
module lsr_rotate #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    input  logic            left,
    input  logic            word,
    output logic [XLEN-1:0] y
);
    logic [SHW-1:0]    r_amt;
    logic [2*XLEN-1:0] dbl;
    logic [XLEN-1:0]   full;

    always_comb begin
        r_amt = left ? ({SHW{1'b0}} - amt) : amt;
        dbl   = {a, a} >> r_amt;
        full  = dbl[XLEN-1:0];
    end

    generate
        if (XLEN == 64) begin : g_word
            logic [4:0]  w_amt;
            logic [63:0] w_dbl;
            logic [31:0] w_res;
            always_comb begin
                w_amt = left ? (5'd0 - amt[4:0]) : amt[4:0];
                w_dbl = {a[31:0], a[31:0]} >> w_amt;
                w_res = w_dbl[31:0];
                y     = word ? {{32{w_res[31]}}, w_res} : full;
            end
        end else begin : g_noword
            assign y = word ? full : full;
        end
    endgenerate
endmodule

// File: rtl/lsr_unit.sv
module lsr_unit
    import lsr_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [SHW-1:0]  imm_amt,
    input  logic            use_imm,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);
    typedef struct packed {
        logic [XLEN-1:0] res;
    } unit_state_t;

    unit_state_t state_d, state_q;

    logic [SHW-1:0]  amount;
    logic [XLEN-1:0] logic_y, bit_y, rot_y;
    logic            rot_left;

    always_comb begin
        rot_left = (op == OP_ROL);
        amount   = (use_imm && !rot_left) ? imm_amt : src_b[SHW-1:0];
    end

    lsr_logic #(.XLEN(XLEN)) u_logic (
        .op (op),
        .a  (src_a),
        .b  (src_b),
        .y  (logic_y)
    );

    lsr_bitop #(.XLEN(XLEN)) u_bitop (
        .op  (op),
        .a   (src_a),
        .idx (amount),
        .y   (bit_y)
    );

    lsr_rotate #(.XLEN(XLEN)) u_rotate (
        .a    (src_a),
        .amt  (amount),
        .left (rot_left),
        .word (word_mode),
        .y    (rot_y)
    );

    always_comb begin
        state_d = state_q;
        case (op_group(op))
            GRP_LOGIC: state_d.res = logic_y;
            GRP_BIT:   state_d.res = bit_y;
            GRP_ROT:   state_d.res = rot_y;
            default:   state_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.res;
endmodule

// File: rtl/lsr_unit_chk.sv
module lsr_unit_chk #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      op,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [SHW-1:0]  imm_amt,
    input logic            use_imm,
    input logic            word_mode,
    input logic [XLEN-1:0] result
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_andn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 4'd0) |-> (result == ($past(src_a) & ~$past(src_b))));

    p_min_signed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 4'd3) |->
        ($signed(result) <= $signed($past(src_a)) && $signed(result) <= $signed($past(src_b))));

    p_maxu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 4'd6) |-> (result >= $past(src_a) && result >= $past(src_b)));

    p_bset_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 4'd7) |->
        ($countones(result ^ $past(src_a)) <= 1 && (result | $past(src_a)) == result));

    p_bext_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 4'd10) |-> (result[XLEN-1:1] == '0));

    p_bad_op_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) > 4'd12) |-> (result == '0));

    generate
        if (XLEN == 64) begin : g_word_chk
            p_word_sext_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_q && $past(word_mode) && ($past(op) == 4'd11 || $past(op) == 4'd12))
                |-> (result[XLEN-1:32] == {(XLEN-32){result[31]}}));
        end
    endgenerate
endmodule

bind lsr_unit lsr_unit_chk #(.XLEN(XLEN)) u_lsr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .imm_amt   (imm_amt),
    .use_imm   (use_imm),
    .word_mode (word_mode),
    .result    (result)
);

// File: tb/tb_lsr_unit.sv
module tb_lsr_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op = '0;
    logic [63:0]     src_a = '0;
    logic [63:0]     src_b = '0;
    logic [5:0]      imm_amt = '0;
    logic            use_imm = 1'b0;
    logic            word_mode = 1'b0;
    logic [63:0]     result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lsr_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
        .imm_amt(imm_amt), .use_imm(use_imm), .word_mode(word_mode), .result(result)
    );

    function automatic logic [63:0] model(input logic [3:0] c, input logic [63:0] a,
                                          input logic [63:0] b, input logic [5:0] im,
                                          input logic ui, input logic wd);
        logic [63:0] r;
        logic [31:0] w;
        int k;
        k = (ui && c != 4'd11) ? int'(im) : int'(b[5:0]);
        r = '0;
        case (c)
            4'd0: r = a & ~b;
            4'd1: r = a | ~b;
            4'd2: r = ~(a ^ b);
            4'd3: r = ($signed(a) < $signed(b)) ? a : b;
            4'd4: r = ($signed(a) > $signed(b)) ? a : b;
            4'd5: r = (a < b) ? a : b;
            4'd6: r = (a > b) ? a : b;
            4'd7: begin r = a; r[k] = 1'b1; end
            4'd8: begin r = a; r[k] = 1'b0; end
            4'd9: begin r = a; r[k] = ~a[k]; end
            4'd10: r = {63'd0, a[k]};
            4'd11, 4'd12: begin
                if (wd) begin
                    w = '0;
                    for (int i = 0; i < 32; i++) begin
                        if (c == 4'd12) w[i] = a[(i + k) % 32];
                        else            w[(i + k) % 32] = a[i];
                    end
                    r = {{32{w[31]}}, w};
                end else begin
                    for (int i = 0; i < 64; i++) begin
                        if (c == 4'd12) r[i] = a[(i + k) % 64];
                        else            r[(i + k) % 64] = a[i];
                    end
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic compare(input logic [63:0] got, input logic [63:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] im, input logic ui, input logic wd, input string tag);
        op = c; src_a = a; src_b = b; imm_amt = im; use_imm = ui; word_mode = wd;
        @(negedge clk);
        compare(result, model(c, a, b, im, ui, wd), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] pat [4];
        pat[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pat[1] = 64'h0000_0000_0000_0000;
        pat[2] = 64'hA5C3_0F96_5A3C_F069;
        pat[3] = 64'h8000_0000_0000_0001;

        // R10: reset holds the result at zero even with active inputs
        op = 4'd1; src_a = 64'h1234;
        repeat (3) @(negedge clk);
        compare(result, 64'd0, "R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: inverted-operand logic
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int c = 0; c < 3; c++)
                    run(4'(c), pat[i], pat[j] ^ 64'h0F0F_0000_FFFF_1111, 6'd0, 1'b0, 1'b0, "R1 logic");

        // R2, R3: signed and unsigned min/max corner pairs
        begin
            logic [63:0] v [6];
            v[0] = 64'h0; v[1] = 64'h1; v[2] = 64'hFFFF_FFFF_FFFF_FFFF;
            v[3] = 64'h7FFF_FFFF_FFFF_FFFF; v[4] = 64'h8000_0000_0000_0000; v[5] = 64'h8000_0000_0000_0001;
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    run(4'd3, v[i], v[j], 6'd0, 1'b0, 1'b0, "R2 min");
                    run(4'd4, v[i], v[j], 6'd0, 1'b0, 1'b0, "R2 max");
                    run(4'd5, v[i], v[j], 6'd0, 1'b0, 1'b0, "R3 minu");
                    run(4'd6, v[i], v[j], 6'd0, 1'b0, 1'b0, "R3 maxu");
                end
        end

        // R4, R5: every index, register amount with upper-bit noise
        for (int k = 0; k < 64; k++)
            for (int p = 0; p < 4; p++) begin
                for (int c = 7; c < 10; c++)
                    run(4'(c), pat[p], {58'h2AB_CDEF_0123_45, 6'(k)}, 6'(63 - k), 1'b0, 1'b0, "R4 bitop reg");
                run(4'd10, pat[p], {58'h155_0000_FFFF_00, 6'(k)}, 6'(k + 1), 1'b0, 1'b0, "R5 bext reg");
            end

        // R8, R9: immediate amount with a differing register amount, word flag raised
        for (int k = 0; k < 64; k++) begin
            for (int c = 7; c < 11; c++)
                run(4'(c), pat[2], 64'(63 - k), 6'(k), 1'b1, 1'b1, "R8 R9 bitop imm");
            run(4'd0, pat[2], 64'(k) * 64'h0101_0101_0101_0101, 6'(k), 1'b1, 1'b1, "R9 logic word flag");
        end

        // R6, R8: full-width rotates, both sources
        for (int k = 0; k < 64; k++) begin
            run(4'd11, pat[2], 64'(k) | 64'hFF00, 6'(63 - k), 1'b0, 1'b0, "R6 rol reg");
            run(4'd12, pat[2], 64'(k) | 64'hFF00, 6'(63 - k), 1'b0, 1'b0, "R6 ror reg");
            run(4'd12, pat[3], 64'(63 - k), 6'(k), 1'b1, 1'b0, "R8 ror imm");
            run(4'd11, pat[3], 64'(k), 6'(63 - k), 1'b1, 1'b0, "R8 rol ignores imm");
        end

        // R7: word rotates, noisy upper halves, amounts 0..63
        for (int k = 0; k < 64; k++)
            for (int s = 0; s < 4; s++) begin
                logic [63:0] a;
                a = {32'hDEAD_BEEF ^ 32'(k * 977), 32'h1 << (s * 8 + 3)};
                run(4'd11, a, {32'hCAFE_F00D, 32'(k)}, 6'(s), 1'b0, 1'b1, "R7 rolw");
                run(4'd12, a, {32'h1357_9BDF, 32'(k)}, 6'(s), 1'b0, 1'b1, "R7 rorw reg");
                run(4'd12, a, {32'hFFFF_FFFF, 32'(s)}, 6'(k), 1'b1, 1'b1, "R7 rorw imm");
            end

        // R11: unused op codes
        for (int c = 13; c < 16; c++)
            for (int p = 0; p < 4; p++)
                run(4'(c), pat[p], pat[3 - p], 6'd5, p[0], p[1], "R11 unused op");

        // R10: one-cycle latency, then reset clears the register
        run(4'd1, 64'h0, 64'h0, 6'd0, 1'b0, 1'b0, "R10 latency");
        rst_n = 1'b0;
        #1;
        compare(result, 64'd0, "R10 async reset");
        report();
    end
endmodule